// File: doc/BRIEF.md
# Multi-Period Disc Position Counter

This block keeps the absolute position of a magnetic code disc that carries several magnetic periods per mechanical turn. An upstream interpolator delivers a 6-bit fine angle within the current period, together with a strobe that fires each time the disc crosses into the next or the previous period. The block counts those crossings in a period counter. The period counter wraps once per turn at a programmable boundary. Each wrap steps a signed 24-bit turn counter up or down.

The number of periods per turn is set by a 16-bit code. The count is the code plus one, so any count from 1 to 65536 works, whether or not it is a power of two. A direction-inversion input mirrors the counting sense and also mirrors the fine angle. The result is a single concatenated position word for the serial output stage. A synchronous preset zeroes both counters.

Top module: `disc_position_counter`

## Requirements
- R1: After reset, rev_count and period_count are 0.
- R2: A forward step (step_valid high, applied direction forward) with period_count below ppr_code raises period_count by one and leaves rev_count unchanged.
- R3: A forward step with period_count equal to ppr_code sets period_count to 0 and raises rev_count by one. One turn therefore spans exactly ppr_code+1 periods, for any code including 0.
- R4: A backward step with period_count above 0 lowers it by one. A backward step at period_count 0 loads ppr_code and lowers rev_count by one.
- R5: rev_count is 24 bits and wraps modulo 2^24: a decrement from 0 gives 0xFFFFFF and an increment from 0xFFFFFF gives 0. rev_count changes only on a period wrap or a preset.
- R6: The applied direction is step_dir XOR dir_invert. step_dir=1 means forward when dir_invert=0.
- R7: fine_pos equals fine_in when dir_invert=0, and 63 minus fine_in when dir_invert=1. fine_pos is combinational from both inputs.
- R8: If period_count exceeds ppr_code, for example after the code was lowered, the next clock edge loads ppr_code. A step on that edge is ignored and rev_count is unchanged.
- R9: preset high at a clock edge zeroes both counters and overrides any step or clamp.
- R10: position is {rev_count, period_count, fine_pos}: fine_pos in bits 5:0, period_count in bits 21:6, rev_count in bits 45:22.
- R11: With step_valid low and period_count within range, both counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Synchronous zeroing of both counters |
| ppr_code | input | 16 | Periods per turn, minus one |
| dir_invert | input | 1 | Reverses counting sense and mirrors fine angle |
| step_valid | input | 1 | One-cycle period-crossing strobe |
| step_dir | input | 1 | Raw crossing direction, 1 = forward |
| fine_in | input | 6 | Fine angle within the current period |
| rev_count | output | 24 | Signed turn count |
| period_count | output | 16 | Period index within the turn |
| fine_pos | output | 6 | Direction-corrected fine angle |
| position | output | 46 | Concatenated absolute position |

## Verification
The hardest case to reach from the ports is a period counter that sits above the boundary. It only arises when ppr_code is lowered after the counter has already advanced. The stimulus steps the counter to 7 under code 9. It then drops the code to 3 on the same cycle as a forward strobe, and checks that the clamp wins, that the strobe is discarded, and that the next step wraps cleanly. The 24-bit turn wrap is reached by a backward step from zero under the largest code, followed by a forward step back. Small codes are swept over several full turns in both directions.

// File: rtl/disc_pos_pkg.sv
package disc_pos_pkg;
  localparam int unsigned DEF_PERIOD_W = 16;
  localparam int unsigned DEF_FINE_W   = 6;
  localparam int unsigned DEF_REV_W    = 24;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BWD  = 2'd2
  } step_e;
endpackage

// File: rtl/dpc_period_counter.sv
module dpc_period_counter
  import disc_pos_pkg::*;
#(
  parameter int unsigned PW = DEF_PERIOD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset,
  input  logic [PW-1:0] code,
  input  step_e         step,
  output logic [PW-1:0] period,
  output logic          wrap_up,
  output logic          wrap_down
);
  logic [PW-1:0] period_q;
  logic          out_of_range;
  logic          stepping;
  logic          clamp_evt;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] cur,
                                            input logic [PW-1:0] lim,
                                            input logic          fwd);
    if (fwd) return (cur >= lim) ? '0 : cur + 1'b1;
    else     return (cur == '0)  ? lim : cur - 1'b1;
  endfunction

  assign out_of_range = (period_q > code);
  assign clamp_evt    = out_of_range & ~preset;
  assign stepping     = (step != STEP_NONE) & ~out_of_range & ~preset;
  assign wrap_up      = stepping & (step == STEP_FWD) & (period_q == code);
  assign wrap_down    = stepping & (step == STEP_BWD) & (period_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        period_q <= '0;
    else if (preset)   period_q <= '0;
    else if (clamp_evt) period_q <= code;
    else if (stepping) period_q <= advance(period_q, code, step == STEP_FWD);
  end

  assign period = period_q;

  a_r8_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_evt |=> (period_q == $past(code)));
  a_r3_fwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_FWD && !preset && period_q == code) |=> (period_q == '0));
  a_r4_bwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_BWD && !preset && period_q == '0) |=> (period_q == $past(code)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_NONE && !preset && period_q <= code) |=> $stable(period_q));
  a_r2_fwd_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_FWD && !preset && period_q < code) |=> (period_q == $past(period_q) + 1'b1));
endmodule

// File: rtl/dpc_rev_counter.sv
module dpc_rev_counter #(
  parameter int unsigned RW = disc_pos_pkg::DEF_REV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preset,
  input  logic          inc,
  input  logic          dec,
  output logic [RW-1:0] rev
);
  logic [RW-1:0] rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rev_q <= '0;
    else if (preset) rev_q <= '0;
    else if (inc)    rev_q <= rev_q + 1'b1;
    else if (dec)    rev_q <= rev_q - 1'b1;
  end

  assign rev = rev_q;

  a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc, dec}));
  a_r3_rev_up: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !preset) |=> (rev_q == RW'($past(rev_q) + 1'b1)));
  a_r4_rev_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !preset) |=> (rev_q == RW'($past(rev_q) - 1'b1)));
  a_r5_rev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !dec && !preset) |=> $stable(rev_q));
  a_r9_preset: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (rev_q == '0));
endmodule

// File: rtl/dpc_fine_map.sv
module dpc_fine_map #(
  parameter int unsigned FW = disc_pos_pkg::DEF_FINE_W
) (
  input  logic [FW-1:0] fine_raw,
  input  logic          invert,
  output logic [FW-1:0] fine_out
);
  localparam logic [FW-1:0] FINE_MAX = {FW{1'b1}};

  function automatic logic [FW-1:0] mirror(input logic [FW-1:0] x, input logic inv);
    return inv ? FINE_MAX - x : x;
  endfunction

  assign fine_out = mirror(fine_raw, invert);

  always_comb begin
    a_r7_mirror: assert (invert || fine_out == fine_raw);
  end
endmodule

// File: rtl/disc_position_counter.sv
module disc_position_counter
  import disc_pos_pkg::*;
#(
  parameter int unsigned PERIOD_W = DEF_PERIOD_W,
  parameter int unsigned FINE_W   = DEF_FINE_W,
  parameter int unsigned REV_W    = DEF_REV_W,
  localparam int unsigned POS_W   = REV_W + PERIOD_W + FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                preset,
  input  logic [PERIOD_W-1:0] ppr_code,
  input  logic                dir_invert,
  input  logic                step_valid,
  input  logic                step_dir,
  input  logic [FINE_W-1:0]   fine_in,
  output logic [REV_W-1:0]    rev_count,
  output logic [PERIOD_W-1:0] period_count,
  output logic [FINE_W-1:0]   fine_pos,
  output logic [POS_W-1:0]    position
);
  step_e step_kind;
  logic  applied_fwd;
  logic  wrap_up;
  logic  wrap_down;

  assign applied_fwd = step_dir ^ dir_invert;
  assign step_kind   = !step_valid ? STEP_NONE : (applied_fwd ? STEP_FWD : STEP_BWD);

  dpc_period_counter #(.PW(PERIOD_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .code     (ppr_code),
    .step     (step_kind),
    .period   (period_count),
    .wrap_up  (wrap_up),
    .wrap_down(wrap_down)
  );

  dpc_rev_counter #(.RW(REV_W)) u_rev (
    .clk   (clk),
    .rst_n (rst_n),
    .preset(preset),
    .inc   (wrap_up),
    .dec   (wrap_down),
    .rev   (rev_count)
  );

  dpc_fine_map #(.FW(FINE_W)) u_fine (
    .fine_raw(fine_in),
    .invert  (dir_invert),
    .fine_out(fine_pos)
  );

  assign position = {rev_count, period_count, fine_pos};

  a_r6_dir_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !preset && period_count < ppr_code && (step_dir ^ dir_invert))
      |=> (period_count == $past(period_count) + 1'b1));
  a_r9_preset_period: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (period_count == '0));
endmodule

// File: tb/disc_position_counter_test.sv
module disc_position_counter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        preset = 0;
  logic [15:0] ppr_code = 0;
  logic        dir_invert = 0;
  logic        step_valid = 0;
  logic        step_dir = 0;
  logic [5:0]  fine_in = 0;
  logic [23:0] rev_count;
  logic [15:0] period_count;
  logic [5:0]  fine_pos;
  logic [45:0] position;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  longint m_per = 0;
  longint m_rev = 0;

  always #2.5 clk = ~clk;

  disc_position_counter uut (
    .clk(clk), .rst_n(rst_n), .preset(preset), .ppr_code(ppr_code),
    .dir_invert(dir_invert), .step_valid(step_valid), .step_dir(step_dir),
    .fine_in(fine_in), .rev_count(rev_count), .period_count(period_count),
    .fine_pos(fine_pos), .position(position)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    logic [23:0] er;
    logic [5:0]  ef;
    er = 24'(m_rev);
    ef = dir_invert ? 6'(63 - int'(fine_in)) : fine_in;
    check(rev_count == er, req, rev_count, er);
    check(period_count == 16'(m_per), req, period_count, m_per);
    check(position == {er, 16'(m_per), ef}, {req, " R10"}, position, {er, 16'(m_per), ef});
  endtask

  // raw direction d; applied direction is d ^ dir_invert (R6)
  task automatic do_step(input bit d);
    longint n;
    @(negedge clk);
    step_valid = 1; step_dir = d;
    @(negedge clk);
    step_valid = 0;
    n = longint'(ppr_code) + 1;
    if (d ^ dir_invert) begin
      m_per = (m_per + 1) % n;
      if (m_per == 0) m_rev = m_rev + 1;
    end else begin
      if (m_per == 0) m_rev = m_rev - 1;
      m_per = (m_per + n - 1) % n;
    end
    m_rev = m_rev & 64'hFFFFFF;
  endtask

  task automatic do_preset();
    @(negedge clk);
    preset = 1; step_valid = 1; step_dir = 1;
    @(negedge clk);
    preset = 0; step_valid = 0;
    m_per = 0; m_rev = 0;
    check_counts("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_counts("R1");

    // R11: no strobe, counters hold
    repeat (5) @(negedge clk);
    check_counts("R11");

    // R2 R3: forward sweep over several codes, decimal and binary counts
    foreach (ppr_code[i]) begin end
    for (int ci = 0; ci < 6; ci++) begin
      int codes[6] = '{0, 1, 4, 9, 31, 99};
      do_preset();
      @(negedge clk); ppr_code = 16'(codes[ci]);
      for (int s = 0; s < 3 * (codes[ci] + 1) + 2; s++) begin
        do_step(1);
        check_counts((m_per == 0) ? "R3" : "R2");
      end
      // R4: backward sweep through more than one turn
      for (int s = 0; s < 4 * (codes[ci] + 1) + 1; s++) begin
        do_step(0);
        check_counts("R4");
      end
    end

    // R6: inversion reverses the applied direction
    do_preset();
    @(negedge clk); ppr_code = 16'd9; dir_invert = 1;
    for (int s = 0; s < 12; s++) begin
      do_step(1);
      check_counts("R6");
    end
    for (int s = 0; s < 25; s++) begin
      do_step(0);
      check_counts("R6");
    end
    @(negedge clk); dir_invert = 0;

    // R7: fine angle sweep in both senses
    for (int inv = 0; inv < 2; inv++) begin
      for (int v = 0; v < 64; v++) begin
        @(negedge clk); dir_invert = inv[0]; fine_in = 6'(v);
        #1;
        check(fine_pos == (inv[0] ? 6'(63 - v) : 6'(v)), "R7", fine_pos, inv[0] ? 63 - v : v);
      end
    end
    @(negedge clk); dir_invert = 0; fine_in = 6'd21;

    // R8: lower the code above the count with a strobe on the same edge
    do_preset();
    @(negedge clk); ppr_code = 16'd9;
    for (int s = 0; s < 7; s++) do_step(1);
    check_counts("R2");
    @(negedge clk);
    ppr_code = 16'd3; step_valid = 1; step_dir = 1;
    @(negedge clk);
    step_valid = 0;
    m_per = 3;
    check_counts("R8");
    do_step(1);
    check_counts("R8 R3");

    // R5: 24-bit turn wrap under the largest code
    do_preset();
    @(negedge clk); ppr_code = 16'hFFFF;
    do_step(0);
    check(rev_count == 24'hFFFFFF, "R5", rev_count, 24'hFFFFFF);
    check(period_count == 16'hFFFF, "R5", period_count, 16'hFFFF);
    do_step(1);
    check(rev_count == 24'h0, "R5", rev_count, 0);
    check(period_count == 16'h0, "R5", period_count, 0);
    do_step(1);
    check_counts("R5 R2");

    // R9: preset overrides a pending step
    do_step(1);
    do_preset();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule